// File: doc/BRIEF.md
# Parallel Port Forward Write Engine

The engine moves bytes from a tagged byte FIFO out to a peripheral over an IEEE 1284-style parallel link. Each FIFO entry holds nine bits: a data byte and a one-bit tag that marks the byte as data or as a command. While the engine is idle, a forward mode is selected and the FIFO is not empty, it pops one entry. It holds the byte on the data lines and sets the AutoFeed line. It then runs a strobe/busy handshake with the peripheral.

The 3-bit mode field selects the behaviour. In the plain FIFO mode (`010`), AutoFeed copies a control-register bit and the strobe is a fixed-width pulse. In the extended mode (`011`), AutoFeed reflects the entry's tag and the strobe is held until the peripheral answers by raising BUSY. The engine does not start its next cycle until BUSY falls again. The empty status follows the end of the peripheral cycle, not the pop. Any other mode value aborts a transfer in progress. FIFO storage, DMA requests and host register decoding sit outside this block.

Top module: `pp_fwd_engine`

## Requirements
- R1: After reset, with the FIFO empty, `stb_out` is 0, `fifo_pop` is 0 and `empty_flag` is 1.
- R2: `fifo_pop` is asserted for one cycle only when `mode` is `010` or `011`, the FIFO is not empty and no write cycle is in progress. There is at most one pop per write cycle. The popped byte (`fifo_rdata[7:0]`) appears on `pd_out` and is held there until the next pop.
- R3: `stb_out` rises only in a cycle after BUSY was sampled low. While BUSY stays high after a pop, the strobe stays deasserted.
- R4: In mode `010`, `stb_out` stays high for exactly `STB_PULSE` cycles whatever BUSY does, and `afd_out` equals `ctl_afd`.
- R5: In mode `011`, `afd_out` is the inverse of the popped tag `fifo_rdata[8]`. Tag 0 (data byte) drives AutoFeed high and tag 1 (command byte) drives it low.
- R6: In mode `011`, `stb_out` stays high while BUSY is low. It falls on the cycle after BUSY is sampled high. No new entry is popped, and `pd_out` does not change, until BUSY has been sampled low again.
- R7: `empty_flag` is 0 from the pop until the write cycle finishes. It is 1 whenever no cycle is in progress and the FIFO is empty.
- R8: A `mode` value other than `010` or `011` drops `stb_out` on the next cycle and prevents any pop. Outside mode `011`, `afd_out` equals `ctl_afd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Operating mode; `010` and `011` enable forward transfers |
| ctl_afd | input | 1 | Control-register AutoFeed level used outside mode `011` |
| fifo_empty | input | 1 | FIFO has no entry |
| fifo_rdata | input | BYTE_W+1 | Head entry, tag in the top bit, byte below |
| fifo_pop | output | 1 | Removes the head entry at this clock edge |
| busy | input | 1 | Peripheral BUSY line |
| pd_out | output | BYTE_W | Parallel data lines |
| afd_out | output | 1 | AutoFeed line level |
| stb_out | output | 1 | Strobe, 1 = asserted |
| empty_flag | output | 1 | Empty status that includes the outstanding peripheral cycle |

## Verification
The hardest situation to reach is the extended-mode gap between the strobe falling and BUSY falling. In that gap the FIFO already has a second entry waiting, and the engine must neither pop it nor change the data lines. The stimulus queues two entries and raises BUSY to end the first strobe. It holds BUSY high for several cycles while it watches the pop pointer and `pd_out`, and only then lowers BUSY. A second difficult case is an abort in the middle of a strobe. The bench changes the mode while the strobe is high and then checks that the remaining entry stays in the FIFO.

// File: rtl/pp_fwd_pkg.sv
package pp_fwd_pkg;

  localparam logic [2:0] MODE_FIFO = 3'b010;
  localparam logic [2:0] MODE_EXT  = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RELEASE = 2'd3
  } hs_state_e;

  function automatic logic mode_is_fwd(input logic [2:0] m);
    return (m == MODE_FIFO) || (m == MODE_EXT);
  endfunction

  function automatic logic afd_level(input logic [2:0] m, input logic ctl, input logic tag);
    return (m == MODE_EXT) ? ~tag : ctl;
  endfunction

endpackage

// File: rtl/pp_fwd_mode_dec.sv
module pp_fwd_mode_dec
  import pp_fwd_pkg::*;
(
  input  logic [2:0] mode,
  output logic       fwd_active,
  output logic       ext_mode
);
  always_comb begin
    fwd_active = mode_is_fwd(mode);
    ext_mode   = (mode == MODE_EXT);
  end
endmodule

// File: rtl/pp_fwd_hold_reg.sv
module pp_fwd_hold_reg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W:0]   entry_in,
  output logic [BYTE_W-1:0] byte_q,
  output logic              tag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      tag_q  <= 1'b0;
    end else if (load) begin
      byte_q <= entry_in[BYTE_W-1:0];
      tag_q  <= entry_in[BYTE_W];
    end
  end
endmodule

// File: rtl/pp_fwd_hs_fsm.sv
module pp_fwd_hs_fsm
  import pp_fwd_pkg::*;
#(
  parameter int STB_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_active,
  input  logic ext_mode,
  input  logic fifo_empty,
  input  logic busy,
  output logic pop,
  output logic strobe,
  output logic cycle_open
);
  localparam int CNT_W = (STB_PULSE < 2) ? 1 : $clog2(STB_PULSE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STB_PULSE - 1);

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pop     = 1'b0;
    if (!fwd_active) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!fifo_empty) begin
            pop     = 1'b1;
            state_d = ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnt_d = '0;
          if (!busy) state_d = ST_STROBE;
        end
        ST_STROBE: begin
          if (ext_mode) begin
            if (busy) state_d = ST_RELEASE;
          end else if (cnt_q >= CNT_LAST) begin
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RELEASE: begin
          if (!busy) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign strobe     = (state_q == ST_STROBE);
  assign cycle_open = (state_q != ST_IDLE);
endmodule

// File: rtl/pp_fwd_engine.sv
module pp_fwd_engine
  import pp_fwd_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STB_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              ctl_afd,
  input  logic              fifo_empty,
  input  logic [BYTE_W:0]   fifo_rdata,
  output logic              fifo_pop,
  input  logic              busy,
  output logic [BYTE_W-1:0] pd_out,
  output logic              afd_out,
  output logic              stb_out,
  output logic              empty_flag
);
  logic fwd_active;
  logic ext_mode;
  logic pop_evt;
  logic cycle_open;
  logic tag_q;

  pp_fwd_mode_dec u_dec (
    .mode       (mode),
    .fwd_active (fwd_active),
    .ext_mode   (ext_mode)
  );

  pp_fwd_hs_fsm #(.STB_PULSE(STB_PULSE)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fwd_active (fwd_active),
    .ext_mode   (ext_mode),
    .fifo_empty (fifo_empty),
    .busy       (busy),
    .pop        (pop_evt),
    .strobe     (stb_out),
    .cycle_open (cycle_open)
  );

  pp_fwd_hold_reg #(.BYTE_W(BYTE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pop_evt),
    .entry_in (fifo_rdata),
    .byte_q   (pd_out),
    .tag_q    (tag_q)
  );

  assign fifo_pop   = pop_evt;
  assign afd_out    = afd_level(mode, ctl_afd, tag_q);
  assign empty_flag = fifo_empty & ~cycle_open;
endmodule

// File: rtl/pp_fwd_engine_chk.sv
module pp_fwd_engine_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              fifo_empty,
  input logic              fifo_pop,
  input logic              busy,
  input logic [BYTE_W-1:0] pd_out,
  input logic              stb_out,
  input logic              empty_flag
);
  logic fwd;
  assign fwd = (mode == 3'b010) || (mode == 3'b011);

  assert_pop_rules_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fwd && !fifo_empty && !stb_out));

  assert_single_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

  assert_pd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_pop |=> $stable(pd_out));

  assert_stb_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_out) |-> !$past(busy));

  assert_ext_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_out && !busy && mode == 3'b011) |=> (stb_out || mode != 3'b011));

  assert_empty_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_out |-> !empty_flag);

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd |=> !stb_out);
endmodule

bind pp_fwd_engine pp_fwd_engine_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .busy       (busy),
  .pd_out     (pd_out),
  .stb_out    (stb_out),
  .empty_flag (empty_flag)
);

// File: tb/pp_fwd_engine_tb.sv
`timescale 1ns/1ps
module pp_fwd_engine_tb;
  localparam int BYTE_W    = 8;
  localparam int STB_PULSE = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        mode = 3'b011;
  logic              ctl_afd = 1'b0;
  logic              busy = 1'b0;
  logic              fifo_pop;
  logic [BYTE_W-1:0] pd_out;
  logic              afd_out, stb_out, empty_flag;

  logic [8:0] fq [16];
  logic [4:0] wr_ptr = '0;
  logic [4:0] rd_ptr;
  logic       fifo_empty;
  logic [8:0] fifo_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ptr <= '0;
    else if (fifo_pop) rd_ptr <= rd_ptr + 5'd1;
  end
  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_rdata = fq[rd_ptr[3:0]];

  pp_fwd_engine #(.BYTE_W(BYTE_W), .STB_PULSE(STB_PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ctl_afd(ctl_afd),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .busy(busy), .pd_out(pd_out), .afd_out(afd_out), .stb_out(stb_out),
    .empty_flag(empty_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic tag, input logic [7:0] d);
    fq[wr_ptr[3:0]] = {tag, d};
    wr_ptr = wr_ptr + 5'd1;
  endtask

  task automatic wait_stb();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (stb_out) break;
    end
  endtask

  // one full forward cycle; last=1 when no entry remains afterwards
  task automatic run_xfer(input logic [2:0] m, input logic [7:0] exp_pd,
                          input logic exp_afd, input bit last);
    int width;
    busy = 1'b0;
    wait_stb();
    chk("R3 strobe seen", int'(stb_out), 1);
    chk("R2 data on lines", int'(pd_out), int'(exp_pd));
    chk(m == 3'b011 ? "R5 afd from tag" : "R4 afd from ctl", int'(afd_out), int'(exp_afd));
    chk("R7 empty low in cycle", int'(empty_flag), 0);
    if (m == 3'b010) begin
      width = 0;
      busy = 1'b1;
      while (stb_out && width < 50) begin
        width++;
        @(negedge clk);
      end
      chk("R4 pulse width", width, STB_PULSE);
      busy = 1'b0;
      if (last) chk("R7 empty after cycle", int'(empty_flag), 1);
    end else begin
      repeat (3) @(negedge clk);
      chk("R6 strobe held busy low", int'(stb_out), 1);
      busy = 1'b1;
      @(negedge clk);
      chk("R6 strobe drop on busy", int'(stb_out), 0);
      repeat (2) @(negedge clk);
      chk("R6 data held until busy low", int'(pd_out), int'(exp_pd));
      chk("R7 empty low until busy low", int'(empty_flag), 0);
      busy = 1'b0;
      @(negedge clk);
      if (last) chk("R7 empty after busy low", int'(empty_flag), 1);
    end
  endtask

  // {mode, ctl_afd, tag, data, expected afd}
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {3'b011, 1'b0, 1'b0, 8'hA5, 1'b1},
    {3'b011, 1'b1, 1'b1, 8'h3C, 1'b0},
    {3'b011, 1'b0, 1'b1, 8'hFF, 1'b0},
    {3'b010, 1'b1, 1'b1, 8'h00, 1'b1},
    {3'b010, 1'b0, 1'b0, 8'h81, 1'b0},
    {3'b010, 1'b0, 1'b1, 8'h5A, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobe at reset", int'(stb_out), 0);
    chk("R1 empty at reset", int'(empty_flag), 1);
    chk("R1 no pop at reset", int'(fifo_pop), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(stb_out), 0);

    for (int v = 0; v < NV; v++) begin
      mode    = VEC[v][13:11];
      ctl_afd = VEC[v][10];
      push(VEC[v][9], VEC[v][8:1]);
      run_xfer(VEC[v][13:11], VEC[v][8:1], VEC[v][0], 1'b1);
    end

    // R3: busy high before strobe holds it off
    mode = 3'b011; busy = 1'b1;
    push(1'b0, 8'h11);
    repeat (5) @(negedge clk);
    chk("R3 no strobe while busy", int'(stb_out), 0);
    chk("R2 popped once", int'(rd_ptr), int'(wr_ptr));
    chk("R7 empty low before strobe", int'(empty_flag), 0);
    run_xfer(3'b011, 8'h11, 1'b1, 1'b1);

    // R6: second entry waits for busy low
    push(1'b1, 8'h22);
    push(1'b0, 8'h33);
    busy = 1'b0;
    wait_stb();
    busy = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 no pop before busy low", int'(wr_ptr - rd_ptr), 1);
    chk("R6 first byte held", int'(pd_out), 8'h22);
    run_xfer(3'b011, 8'h33, 1'b1, 1'b1);

    // R8: abort in mid strobe
    ctl_afd = 1'b1;
    push(1'b1, 8'h44);
    push(1'b1, 8'h55);
    busy = 1'b0;
    wait_stb();
    chk("R5 afd command", int'(afd_out), 0);
    mode = 3'b000;
    @(negedge clk);
    chk("R8 strobe dropped", int'(stb_out), 0);
    chk("R8 afd from ctl", int'(afd_out), 1);
    repeat (4) @(negedge clk);
    chk("R8 no pop when inactive", int'(wr_ptr - rd_ptr), 1);
    chk("R8 strobe stays low", int'(stb_out), 0);
    mode = 3'b011;
    run_xfer(3'b011, 8'h55, 1'b0, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule